// File: doc/BRIEF.md
# Reversible Binary Counter with Cascade Strobe

This block is a small binary counter (four bits by default) that steps up or down by one on each rising clock edge while its active-low enable is asserted. An active-low load input forces the counter to a parallel data word at once, without a clock edge, and takes priority over every other mode. Counting wraps modulo 2^WIDTH in both directions.

Two outputs serve cascading. A terminal flag marks the last value before a wrap in the current direction: all ones when counting up, zero when counting down. An active-low cascade strobe pulses low for the low half of the clock period when the counter is enabled and at its terminal value. A following counter can use the strobe as its clock, or as its enable while sharing the common clock.

The internal mode is one of four named states, chosen again each cycle: LOAD (load asserted), HOLD (enable deasserted), UP (enabled, direction low) and DOWN (enabled, direction high). Transitions: any state goes to LOAD while load is low. It goes to HOLD when load is high and enable is high. It goes to UP or DOWN when load is high and enable is low, chosen by the direction input.

Top module: `updn_ripple_counter`

## Requirements
- R1: While `load_n` is 0, `count` equals `load_val` immediately, with no clock edge, whatever `cnt_en_n`, `dir_down` and `clk` do.
- R2: With `load_n` 1 and `cnt_en_n` 1, `count` does not change across rising clock edges.
- R3: With `load_n` 1, `cnt_en_n` 0 and `dir_down` 0, `count` increases by one at each rising clock edge.
- R4: With `load_n` 1, `cnt_en_n` 0 and `dir_down` 1, `count` decreases by one at each rising clock edge.
- R5: Counting up wraps from all ones to 0, and counting down wraps from 0 to all ones.
- R6: `term_cnt` is 1 exactly when `count` is all ones with `dir_down` 0, or `count` is 0 with `dir_down` 1. It does not depend on `cnt_en_n`.
- R7: Changing `dir_down` alone, with no edge, updates `term_cnt` at once. For example, at all ones, a switch to down clears it.
- R8: `ripple_n` is 0 only while `cnt_en_n` is 0, `term_cnt` is 1 and `clk` is 0. It is 1 during the clock high phase.
- R9: While `cnt_en_n` is 1, `ripple_n` stays 1 even when `term_cnt` is 1.
- R10: When `load_n` returns to 1 between edges, `count` keeps the loaded value until the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| load_n | input | 1 | Active-low asynchronous parallel load |
| cnt_en_n | input | 1 | Active-low count enable |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| load_val | input | WIDTH | Parallel preset word |
| count | output | WIDTH | Current counter value |
| term_cnt | output | 1 | Terminal value for the present direction |
| ripple_n | output | 1 | Active-low cascade strobe, clock low phase only |

## Verification
The bench loads every value in both directions, with enable on and off, and predicts each result arithmetically. Its checks target the wrap points, where a design that saturates or skips would leave or jump the range. It also checks a direction flip at a terminal value: a design that registered the flag would hold it for a cycle. It samples the strobe in both clock phases, where a design that ignored the clock level or the enable would pulse during the high phase or while disabled. It presets during counting and releases the load between edges, where a design that loaded only on an edge, or stepped on release, would show the wrong value.

// File: rtl/updn_ctr_pkg.sv
package updn_ctr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD = 2'd0,
        MODE_UP   = 2'd1,
        MODE_DOWN = 2'd2,
        MODE_LOAD = 2'd3
    } ctr_mode_e;
endpackage

// File: rtl/ctr_mode_sel.sv
module ctr_mode_sel
    import updn_ctr_pkg::*;
(
    input  logic      load_n,
    input  logic      cnt_en_n,
    input  logic      dir_down,
    output ctr_mode_e mode
);
    // Load wins, then the enable, then direction picks the counting mode.
    always_comb begin
        if (!load_n)
            mode = MODE_LOAD;
        else if (cnt_en_n)
            mode = MODE_HOLD;
        else if (dir_down)
            mode = MODE_DOWN;
        else
            mode = MODE_UP;
    end
endmodule

// File: rtl/ctr_state_reg.sv
module ctr_state_reg
    import updn_ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             load_n,
    input  logic [WIDTH-1:0] load_val,
    input  ctr_mode_e        mode,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] state_q;

    // State register: asynchronous load, otherwise stepped by the mode.
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) begin
            state_q <= load_val;
        end else begin
            unique case (mode)
                MODE_UP:   state_q <= state_q + ONE;
                MODE_DOWN: state_q <= state_q - ONE;
                MODE_HOLD: state_q <= state_q;
                MODE_LOAD: state_q <= load_val;
            endcase
        end
    end

    // Output: the preset word passes straight through while load is held.
    always_comb begin
        count = load_n ? state_q : load_val;
    end

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!load_n)
        (mode == MODE_UP) |=> (state_q == WIDTH'($past(state_q) + ONE))); // R3
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!load_n)
        (mode == MODE_DOWN) |=> (state_q == WIDTH'($past(state_q) - ONE))); // R4
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!load_n)
        (mode == MODE_HOLD) |=> $stable(state_q)); // R2
endmodule

// File: rtl/ctr_term_decode.sv
module ctr_term_decode #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] count,
    input  logic             dir_down,
    output logic             term_cnt
);
    localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] BOT_VAL = '0;

    always_comb begin
        term_cnt = dir_down ? (count == BOT_VAL) : (count == TOP_VAL);
    end
endmodule

// File: rtl/ctr_ripple_gate.sv
module ctr_ripple_gate (
    input  logic clk,
    input  logic cnt_en_n,
    input  logic term_cnt,
    output logic ripple_n
);
    // Low only in the clock low phase, when enabled and at terminal.
    always_comb begin
        ripple_n = ~(~cnt_en_n & term_cnt & ~clk);
    end
endmodule

// File: rtl/updn_ripple_counter.sv
module updn_ripple_counter
    import updn_ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             load_n,
    input  logic             cnt_en_n,
    input  logic             dir_down,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] count,
    output logic             term_cnt,
    output logic             ripple_n
);
    ctr_mode_e mode;

    ctr_mode_sel u_mode (
        .load_n   (load_n),
        .cnt_en_n (cnt_en_n),
        .dir_down (dir_down),
        .mode     (mode)
    );

    ctr_state_reg #(.WIDTH(WIDTH)) u_state (
        .clk      (clk),
        .load_n   (load_n),
        .load_val (load_val),
        .mode     (mode),
        .count    (count)
    );

    ctr_term_decode #(.WIDTH(WIDTH)) u_term (
        .count    (count),
        .dir_down (dir_down),
        .term_cnt (term_cnt)
    );

    ctr_ripple_gate u_ripple (
        .clk      (clk),
        .cnt_en_n (cnt_en_n),
        .term_cnt (term_cnt),
        .ripple_n (ripple_n)
    );

    // Sampled just before the rising edge, so clk was low in these values.
    AST_LOAD_PASS: assert property (@(posedge clk)
        (!load_n) |-> (count == load_val)); // R1
    AST_STROBE_LOW: assert property (@(posedge clk) disable iff (!load_n)
        (!cnt_en_n && term_cnt) |-> !ripple_n); // R8
    AST_STROBE_MASKED: assert property (@(posedge clk) disable iff (!load_n)
        cnt_en_n |-> ripple_n); // R9
endmodule

// File: tb/updn_ripple_counter_tb.sv
module updn_ripple_counter_tb;
    localparam int W   = 4;
    localparam int TOP = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         load_n = 1'b0;
    logic         cnt_en_n = 1'b1;
    logic         dir_down = 1'b0;
    logic [W-1:0] load_val = '0;
    logic [W-1:0] count;
    logic         term_cnt;
    logic         ripple_n;

    int checks = 0;
    int fails  = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    updn_ripple_counter #(.WIDTH(W)) u_dut (
        .clk(clk), .load_n(load_n), .cnt_en_n(cnt_en_n), .dir_down(dir_down),
        .load_val(load_val), .count(count), .term_cnt(term_cnt), .ripple_n(ripple_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_term(input int v, input bit dn);
        return dn ? int'(v == 0) : int'(v == TOP);
    endfunction

    // Called in the high phase; runs one full period and returns in the next high phase.
    task automatic cycle();
        int lowexp;
        @(negedge clk); #5;
        lowexp = (!cnt_en_n && exp_term(exp_cnt, dir_down)) ? 0 : 1;
        chk(cnt_en_n ? "R9 strobe masked" : "R8 strobe low phase", int'(ripple_n), lowexp);
        @(posedge clk); #5;
        if (!load_n) exp_cnt = int'(load_val);
        else if (!cnt_en_n) exp_cnt = dir_down ? (exp_cnt + TOP) % (TOP + 1)
                                               : (exp_cnt + 1) % (TOP + 1);
        chk(load_n ? (cnt_en_n ? "R2 hold" : (dir_down ? "R4 down" : "R3 up")) : "R1 load",
            int'(count), exp_cnt);
        chk("R6 terminal", int'(term_cnt), exp_term(exp_cnt, dir_down));
        chk("R8 strobe high phase", int'(ripple_n), 1);
    endtask

    task automatic preset(input int v);
        load_val = W'(v);
        load_n = 1'b0;
        #1;
        chk("R1 immediate load", int'(count), v);
        exp_cnt = v;
        cycle();
        load_n = 1'b1;
        #1;
        chk("R10 no step on release", int'(count), v);
    endtask

    initial begin
        #1;
        chk("R1 reset by load", int'(count), 0);
        @(posedge clk); #5;
        exp_cnt = 0;
        // Sweep every start value, both directions, enable on and off.
        for (int d = 0; d < 2; d++) begin
            for (int e = 0; e < 2; e++) begin
                for (int v = 0; v <= TOP; v++) begin
                    dir_down = d[0];
                    cnt_en_n = e[0];
                    preset(v);
                    cycle();
                end
            end
        end
        // Long runs through the wrap points.
        cnt_en_n = 1'b0;
        dir_down = 1'b0;
        preset(TOP - 2);
        for (int i = 0; i < 20; i++) cycle();
        chk("R5 wrap up", int'(count), (TOP - 2 + 20) % (TOP + 1));
        dir_down = 1'b1;
        preset(2);
        for (int i = 0; i < 20; i++) cycle();
        chk("R5 wrap down", int'(count), (2 - 20 + 2 * (TOP + 1)) % (TOP + 1));
        // Preset while counting, held through an edge.
        dir_down = 1'b0;
        cycle();
        preset(9);
        cycle();
        chk("R1 preset during count", int'(count), 10);
        // Direction change alone at the top value.
        preset(TOP);
        chk("R6 top up", int'(term_cnt), 1);
        dir_down = 1'b1;
        #1;
        chk("R7 direction clears flag", int'(term_cnt), 0);
        dir_down = 1'b0;
        #1;
        chk("R7 direction restores flag", int'(term_cnt), 1);
        // Flag independent of enable.
        cnt_en_n = 1'b1;
        #1;
        chk("R6 flag ignores enable", int'(term_cnt), 1);
        cycle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule